// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register Bank

This block is the register front end of an 8-bit indexed-colour display controller. A processor reaches it through a simple 32-bit word bus with one write strobe and one read strobe. The block keeps the control word, the active width and line count, the screen start offset and the cursor position, and it drives these values straight out to the pixel side. It decodes three windows. Two of them, the colour palette and the cursor pattern, are write ports onto memories that sit outside the block. The third, the three-entry cursor colour table, is held inside the block.

Width and height are written in scaled units: width in groups of four pixels, height in half lines. A set of video-timing addresses is accepted and quietly dropped. A write to the soft-reset address returns the bank to its power-up state. Either reset then runs a sweep that writes zero to every pattern entry and every palette entry of the external memories. The interrupt rises when the display side reports a finished frame, and any bus write lowers it.

Top module: `fbctl_regbank`

## Requirements
- R1: A write to byte address 0x118 sets `width_px` to the written value times four, truncated to DIM_W bits. A read of 0x118 returns `width_px` divided by four.
- R2: A write to 0x150 sets `height_ln` to the written value shifted right by one. A read of 0x150 returns `height_ln` times two, so an odd written value reads back one lower.
- R3: A write to 0x300 stores the full 32-bit control word, and a read returns it unchanged. `blank_force` follows bit 10 and `cursor_off` follows bit 23.
- R4: `pix_depth` decodes control bits 22:20. Codes 0 to 5 give 1, 2, 4, 8, 15 and 16. Codes 6 and 7 give 0. After reset the code is 0, so `pix_depth` is 1.
- R5: Writes to 0x400 set `screen_start`. Writes to 0x638 set the cursor position, with `cursor_y` taken from bits 11:0 and `cursor_x` from bits 23:12. Both addresses are write-only, and a read of either behaves as an unmapped read.
- R6: A write anywhere in 0x800–0xFFF pulses `pal_we` in the same cycle. `pal_idx` is bits 10:3 of the address, and `pal_rgb` carries red in 23:16, green in 15:8 and blue in 7:0 of the write data.
- R7: Addresses 0x508–0x51F hold three cursor colours, each selected by (address − 0x508) >> 3. A write keeps bits 23:0. A read returns them in the same layout, with bits 31:24 zero.
- R8: A write anywhere in 0x1000–0x1FFF pulses `pat_we`. `pat_idx` is bits 11:3 of the address and `pat_data` is bits 15:0 of the write data. A read of the window returns the external word on `pat_rdata`, zero-extended. That word is the one the memory delivers one clock after `pat_idx` is presented.
- R9: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no state, produce no memory write and raise no error.
- R10: A write to 0x100000, like `rst`, clears the control word, width, height, screen start, cursor position, cursor colours and the interrupt. It then runs a sweep of exactly PAT_N cycles. The sweep writes zero to pattern indices 0..PAT_N−1 in order, and to palette indices 0..PAL_N−1 during its first PAL_N cycles. Bus writes into either external window are dropped while the sweep runs.
- R11: A read of any address outside R1–R3, R7 and R8 returns zero and raises `bus_err` for one cycle. A write to an address that none of R1–R3 and R5–R10 names has no effect except that one-cycle `bus_err`.
- R12: `frame_done` sets `irq_out` on the next edge. Any bus write clears it on the next edge, and a write wins when both occur in the same cycle.
- R13: Read data and `bus_err` appear in the cycle after the strobe. `bus_rdata` is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_err | output | 1 | One-cycle unmapped-access flag |
| frame_done | input | 1 | Frame-complete pulse from the display side |
| irq_out | output | 1 | Frame interrupt |
| width_px | output | DIM_W | Active width in pixels |
| height_ln | output | DIM_W | Active line count |
| pix_depth | output | 5 | Decoded bits per pixel |
| blank_force | output | 1 | Force-blank control |
| cursor_off | output | 1 | Cursor-disable control |
| screen_start | output | 32 | Screen start offset |
| cursor_x | output | CUR_XW | Cursor column |
| cursor_y | output | 12 | Cursor line |
| pal_we | output | 1 | Colour palette write enable |
| pal_idx | output | PAL_IW | Colour palette index |
| pal_rgb | output | 24 | Colour palette write data |
| pat_we | output | 1 | Cursor pattern write enable |
| pat_idx | output | PAT_IW | Cursor pattern index, write or read |
| pat_data | output | 16 | Cursor pattern write data |
| pat_rdata | input | 16 | Cursor pattern read word, one clock after `pat_idx` |

## Verification
The assertions rely on the two strobes never being high in the same cycle, and the bench issues every access as a single one-cycle strobe of one kind. They also rely on `frame_done` being low while `rst` is high. They take the pattern memory to answer one clock after `pat_idx`, which the bench's own memory model does. The bench reads the pattern window only after a sweep has ended. It waits well past PAT_N cycles after each reset, so no read or write check overlaps a sweep except the one that probes the drop rule.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    localparam logic [31:0] A_WIDTH   = 32'h0000_0118;
    localparam logic [31:0] A_HEIGHT  = 32'h0000_0150;
    localparam logic [31:0] A_CTRL    = 32'h0000_0300;
    localparam logic [31:0] A_START   = 32'h0000_0400;
    localparam logic [31:0] A_CPOS    = 32'h0000_0638;
    localparam logic [31:0] A_CPAL_LO = 32'h0000_0508;
    localparam logic [31:0] A_CPAL_HI = 32'h0000_0520;
    localparam logic [31:0] A_PAL_LO  = 32'h0000_0800;
    localparam logic [31:0] A_PAT_LO  = 32'h0000_1000;
    localparam logic [31:0] A_SRST    = 32'h0010_0000;

    localparam int unsigned CPAL_N     = 3;
    localparam int unsigned CY_W       = 12;
    localparam int unsigned CB_BLANK   = 10;
    localparam int unsigned CB_NOCUR   = 23;
    localparam int unsigned CB_DEPTH   = 20;

    typedef enum logic [3:0] {
        K_NONE, K_WIDTH, K_HEIGHT, K_CTRL, K_START, K_CPOS,
        K_CPAL, K_PAL, K_PAT, K_TIMING, K_SRST
    } acc_kind_e;

    typedef struct packed {
        logic [31:0] data;
        logic        err;
        logic        from_pat;
    } rd_rsp_t;

    function automatic logic [4:0] depth_of(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd15;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic is_timing(input logic [31:0] a);
        case (a)
            32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
            32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned PAL_N  = 256,
    parameter int unsigned PAT_N  = 512,
    localparam int unsigned PAL_IW = $clog2(PAL_N),
    localparam int unsigned PAT_IW = $clog2(PAT_N)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [PAT_IW-1:0] idx
);
    localparam logic [31:0] PAL_END = A_PAL_LO + 32'(PAL_N * 8);
    localparam logic [31:0] PAT_END = A_PAT_LO + 32'(PAT_N * 8);

    logic [31:0] a;
    logic [1:0]  cpal_sel;

    assign a        = 32'(addr);
    assign cpal_sel = addr[4:3] - 2'd1;

    always_comb begin
        kind = K_NONE;
        idx  = '0;
        if (a >= A_PAL_LO && a < PAL_END) begin
            kind = K_PAL;
            idx  = PAT_IW'(addr[PAL_IW+2:3]);
        end else if (a >= A_PAT_LO && a < PAT_END) begin
            kind = K_PAT;
            idx  = addr[PAT_IW+2:3];
        end else if (a >= A_CPAL_LO && a < A_CPAL_HI) begin
            kind = K_CPAL;
            idx  = PAT_IW'(cpal_sel);
        end else begin
            case (a)
                A_WIDTH:  kind = K_WIDTH;
                A_HEIGHT: kind = K_HEIGHT;
                A_CTRL:   kind = K_CTRL;
                A_START:  kind = K_START;
                A_CPOS:   kind = K_CPOS;
                A_SRST:   kind = K_SRST;
                default:  kind = is_timing(a) ? K_TIMING : K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fbctl_sweep.sv
module fbctl_sweep #(
    parameter int unsigned PAL_N = 256,
    parameter int unsigned PAT_N = 512,
    localparam int unsigned PAT_IW = $clog2(PAT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              pal_en,
    output logic [PAT_IW-1:0] idx
);
    localparam logic [PAT_IW-1:0] LAST = PAT_IW'(PAT_N - 1);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST) begin
                busy <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign pal_en = busy && (32'(idx) < PAL_N);
endmodule

// File: rtl/fbctl_irq.sv
module fbctl_irq (
    input  logic clk,
    input  logic rst,
    input  logic any_wr,
    input  logic frame_done,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || any_wr) begin
            irq <= 1'b0;
        end else if (frame_done) begin
            irq <= 1'b1;
        end
    end
endmodule

// File: rtl/fbctl_regbank.sv
module fbctl_regbank
    import fbctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned DIM_W  = 16,
    parameter int unsigned CUR_XW = 12,
    parameter int unsigned PAL_N  = 256,
    parameter int unsigned PAT_N  = 512,
    localparam int unsigned PAL_IW = $clog2(PAL_N),
    localparam int unsigned PAT_IW = $clog2(PAT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              frame_done,
    output logic              irq_out,
    output logic [DIM_W-1:0]  width_px,
    output logic [DIM_W-1:0]  height_ln,
    output logic [4:0]        pix_depth,
    output logic              blank_force,
    output logic              cursor_off,
    output logic [31:0]       screen_start,
    output logic [CUR_XW-1:0] cursor_x,
    output logic [11:0]       cursor_y,
    output logic              pal_we,
    output logic [PAL_IW-1:0] pal_idx,
    output logic [23:0]       pal_rgb,
    output logic              pat_we,
    output logic [PAT_IW-1:0] pat_idx,
    output logic [15:0]       pat_data,
    input  logic [15:0]       pat_rdata
);
    localparam int unsigned CPOS_W = CUR_XW + CY_W;

    acc_kind_e         kind;
    logic [PAT_IW-1:0] idx;
    logic              srst;
    logic              busy;
    logic              sw_pal_en;
    logic [PAT_IW-1:0] sw_idx;

    logic [31:0]       ctrl_q;
    logic [CPOS_W-1:0] cpos_q;
    logic [23:0]       cpal_q [CPAL_N];
    rd_rsp_t           rsp_d;
    rd_rsp_t           rsp_q;

    fbctl_decode #(.ADDR_W(ADDR_W), .PAL_N(PAL_N), .PAT_N(PAT_N)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    assign srst = bus_wr && (kind == K_SRST);

    fbctl_sweep #(.PAL_N(PAL_N), .PAT_N(PAT_N)) u_sweep (
        .clk    (clk),
        .rst    (rst),
        .start  (srst),
        .busy   (busy),
        .pal_en (sw_pal_en),
        .idx    (sw_idx)
    );

    fbctl_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .any_wr     (bus_wr),
        .frame_done (frame_done),
        .irq        (irq_out)
    );

    // scalar registers
    always_ff @(posedge clk) begin
        if (rst || srst) begin
            ctrl_q       <= '0;
            width_px     <= '0;
            height_ln    <= '0;
            screen_start <= '0;
            cpos_q       <= '0;
        end else if (bus_wr) begin
            case (kind)
                K_WIDTH:  width_px     <= DIM_W'({bus_wdata, 2'b00});
                K_HEIGHT: height_ln    <= DIM_W'(bus_wdata >> 1);
                K_CTRL:   ctrl_q       <= bus_wdata;
                K_START:  screen_start <= bus_wdata;
                K_CPOS:   cpos_q       <= bus_wdata[CPOS_W-1:0];
                default:  ;
            endcase
        end
    end

    // cursor colour entries
    for (genvar g = 0; g < CPAL_N; g++) begin : g_cpal
        always_ff @(posedge clk) begin
            if (rst || srst) begin
                cpal_q[g] <= '0;
            end else if (bus_wr && kind == K_CPAL && idx == PAT_IW'(g)) begin
                cpal_q[g] <= bus_wdata[23:0];
            end
        end
    end

    assign pix_depth   = depth_of(ctrl_q[CB_DEPTH+2:CB_DEPTH]);
    assign blank_force = ctrl_q[CB_BLANK];
    assign cursor_off  = ctrl_q[CB_NOCUR];
    assign cursor_y    = cpos_q[CY_W-1:0];
    assign cursor_x    = cpos_q[CPOS_W-1:CY_W];

    // external memory write ports: sweep owns them while busy
    always_comb begin
        if (busy) begin
            pat_we   = 1'b1;
            pat_idx  = sw_idx;
            pat_data = '0;
            pal_we   = sw_pal_en;
            pal_idx  = sw_idx[PAL_IW-1:0];
            pal_rgb  = '0;
        end else begin
            pat_we   = bus_wr && (kind == K_PAT);
            pat_idx  = idx;
            pat_data = bus_wdata[15:0];
            pal_we   = bus_wr && (kind == K_PAL);
            pal_idx  = idx[PAL_IW-1:0];
            pal_rgb  = bus_wdata[23:0];
        end
    end

    // read response
    always_comb begin
        rsp_d = '0;
        if (bus_rd) begin
            case (kind)
                K_WIDTH:  rsp_d.data = 32'(width_px >> 2);
                K_HEIGHT: rsp_d.data = 32'({height_ln, 1'b0});
                K_CTRL:   rsp_d.data = ctrl_q;
                K_CPAL:   rsp_d.data = {8'h00, cpal_q[idx[1:0]]};
                K_PAT:    rsp_d.from_pat = 1'b1;
                default:  rsp_d.err = 1'b1;
            endcase
        end else if (bus_wr && kind == K_NONE) begin
            rsp_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata = rsp_q.from_pat ? 32'(pat_rdata) : rsp_q.data;
    assign bus_err   = rsp_q.err;
endmodule

// File: rtl/fbctl_checker.sv
module fbctl_checker
    import fbctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned DIM_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              frame_done,
    input logic              irq_out,
    input logic [DIM_W-1:0]  width_px,
    input logic              blank_force,
    input logic              cursor_off,
    input logic              pat_we,
    input logic [15:0]       pat_data,
    input logic              pal_we,
    input logic [23:0]       pal_rgb
);
    p_irq_set_r12: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !bus_wr) |=> irq_out);

    p_irq_clr_r12: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !irq_out);

    p_err_cause_r11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_rd || bus_wr));

    p_width_rd_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && 32'(bus_addr) == A_WIDTH)
        |=> (bus_rdata == 32'(width_px >> 2)) && !bus_err);

    p_ctrl_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && 32'(bus_addr) == A_CTRL)
        |=> (bus_rdata[CB_BLANK] == blank_force) && (bus_rdata[CB_NOCUR] == cursor_off));

    p_sweep_pat_r10: assert property (@(posedge clk) disable iff (rst)
        (pat_we && !bus_wr) |-> (pat_data == 16'h0000));

    p_sweep_pal_r10: assert property (@(posedge clk) disable iff (rst)
        (pal_we && !bus_wr) |-> (pal_rgb == 24'h000000));

    p_idle_rd_r13: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'h0));
endmodule

bind fbctl_regbank fbctl_checker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (.*);

// File: tb/test_fbctl_regbank.sv
module test_fbctl_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int PAL_N = 256;
    localparam int PAT_N = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        frame_done = 1'b0;
    logic        irq_out;
    logic [15:0] width_px, height_ln;
    logic [4:0]  pix_depth;
    logic        blank_force, cursor_off;
    logic [31:0] screen_start;
    logic [11:0] cursor_x, cursor_y;
    logic        pal_we, pat_we;
    logic [7:0]  pal_idx;
    logic [23:0] pal_rgb;
    logic [8:0]  pat_idx;
    logic [15:0] pat_data;
    logic [15:0] pat_rdata;

    logic [15:0] pmem [PAT_N];
    logic [23:0] cmem [PAL_N];
    int n_chk = 0, n_fail = 0;
    int pcnt = 0, lcnt = 0, pnz = 0, lnz = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbctl_regbank i_fbctl_regbank (.*);

    // external memories with one-clock read
    initial begin
        for (int i = 0; i < PAT_N; i++) pmem[i] = 16'hFFFF;
        for (int i = 0; i < PAL_N; i++) cmem[i] = 24'hFFFFFF;
    end
    always @(posedge clk) begin
        if (pat_we) pmem[pat_idx] <= pat_data;
        if (pal_we) cmem[pal_idx] <= pal_rgb;
        pat_rdata <= pmem[pat_idx];
        if (!rst) begin
            if (pat_we) begin pcnt <= pcnt + 1; if (pat_data != 0) pnz <= pnz + 1; end
            if (pal_we) begin lcnt <= lcnt + 1; if (pal_rgb != 0) lnz <= lnz + 1; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a[20:0]; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] q, output logic e);
        bus_addr = a[20:0]; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata; e = bus_err;
    endtask

    function automatic logic [4:0] exp_depth(input int d);
        if (d < 4) return 5'(1 << d);
        if (d == 4) return 5'd15;
        if (d == 5) return 5'd16;
        return 5'd0;
    endfunction

    task automatic check_cleared(input string tag, input int p0, input int l0, input int pz0, input int lz0);
        int bad;
        chk({tag, " pattern write count"}, 32'(pcnt - p0), 32'(PAT_N));
        chk({tag, " palette write count"}, 32'(lcnt - l0), 32'(PAL_N));
        chk({tag, " nonzero sweep data"}, 32'((pnz - pz0) + (lnz - lz0)), 32'd0);
        bad = 0;
        for (int i = 0; i < PAT_N; i++) if (pmem[i] != 0) bad++;
        for (int i = 0; i < PAL_N; i++) if (cmem[i] != 0) bad++;
        chk({tag, " memories zero"}, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic e;
        int p0, l0, pz0, lz0;
        logic [31:0] tadr [14] = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
                                   32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200};
        logic [31:0] wv [7] = '{32'h0, 32'h1, 32'h3, 32'h1234, 32'h3FFF, 32'h4000, 32'hFFFFFFFF};

        repeat (3) @(negedge clk);
        // reset state (R4, R12, R13)
        chk("R12 irq after reset", 32'(irq_out), 0);
        chk("R1 width after reset", 32'(width_px), 0);
        chk("R4 depth after reset", 32'(pix_depth), 1);
        chk("R13 rdata after reset", bus_rdata, 0);
        p0 = pcnt; l0 = lcnt; pz0 = pnz; lz0 = lnz;
        rst = 1'b0;
        repeat (PAT_N + 20) @(negedge clk);
        check_cleared("R10 hard reset sweep", p0, l0, pz0, lz0);

        // R1
        foreach (wv[k]) begin
            wr(32'h118, wv[k]);
            chk("R1 width_px", 32'(width_px), (wv[k] * 4) & 32'hFFFF);
            rd(32'h118, q, e);
            chk("R1 width read", q, wv[k] & 32'h3FFF);
            chk("R1 width read err", 32'(e), 0);
        end
        // R2
        for (int v = 0; v < 12; v++) begin
            wr(32'(v), 32'(v)); // timing address 0x000 only for v==0, others unmapped: no state
            wr(32'h150, 32'(v));
            chk("R2 height_ln", 32'(height_ln), 32'(v / 2));
            rd(32'h150, q, e);
            chk("R2 height read", q, 32'((v / 2) * 2));
        end
        wr(32'h150, 32'h1FFFF);
        chk("R2 height trunc", 32'(height_ln), 32'hFFFF);
        // R3 / R4
        for (int d = 0; d < 8; d++) begin
            for (int b = 0; b < 4; b++) begin
                logic [31:0] w;
                w = (32'(d) << 20) | (32'(b & 1) << 10) | (32'(b >> 1) << 23) | 32'h0F00_0005;
                wr(32'h300, w);
                chk("R4 depth decode", 32'(pix_depth), 32'(exp_depth(d)));
                chk("R3 blank bit10", 32'(blank_force), 32'(b & 1));
                chk("R3 cursor off bit23", 32'(cursor_off), 32'(b >> 1));
                rd(32'h300, q, e);
                chk("R3 ctrl read", q, w);
            end
        end
        // R5
        wr(32'h400, 32'hDEADBEEF);
        chk("R5 screen start", screen_start, 32'hDEADBEEF);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] xv, yv;
            xv = 32'(k * 1000 + 7) & 32'hFFF;
            yv = 32'(k * 333 + 1) & 32'hFFF;
            wr(32'h638, 32'hFF00_0000 | (xv << 12) | yv);
            chk("R5 cursor x", 32'(cursor_x), xv);
            chk("R5 cursor y", 32'(cursor_y), yv);
        end
        rd(32'h400, q, e);
        chk("R5 start read data", q, 0);
        chk("R5 start read err", 32'(e), 1);
        // R6
        for (int i = 0; i < PAL_N; i++)
            wr(32'h800 + 32'(i * 8) + 32'((i % 2) * 4), {8'hA5, 8'(i), ~8'(i), 8'(i) ^ 8'h5A});
        for (int i = 0; i < PAL_N; i++)
            chk("R6 palette entry", 32'(cmem[i]), 32'({8'(i), ~8'(i), 8'(i) ^ 8'h5A}));
        // R8
        for (int i = 0; i < PAT_N; i++)
            wr(32'h1000 + 32'(i * 8), 32'hCAFE_0000 | 32'(16'h8000 | 16'(i * 7)));
        for (int i = 0; i < PAT_N; i++)
            chk("R8 pattern entry", 32'(pmem[i]), 32'(16'h8000 | 16'(i * 7)));
        for (int i = 0; i < PAT_N; i += 73) begin
            rd(32'h1000 + 32'(i * 8), q, e);
            chk("R8 pattern read", q, 32'(16'h8000 | 16'(i * 7)));
        end
        // R7
        for (int c = 0; c < 3; c++) wr(32'h508 + 32'(c * 8), 32'hFF00_0000 | 32'(24'h102030 * (c + 1)));
        for (int c = 0; c < 3; c++) begin
            rd(32'h508 + 32'(c * 8) + 32'(c), q, e);
            chk("R7 cursor colour read", q, 32'(24'h102030 * (c + 1)));
        end
        rd(32'h520, q, e);
        chk("R7 above window err", 32'(e), 1);
        rd(32'h500, q, e);
        chk("R7 below window err", 32'(e), 1);
        // R9
        wr(32'h118, 32'h55);
        wr(32'h300, 32'h0030_0000);
        p0 = pcnt; l0 = lcnt;
        foreach (tadr[k]) begin
            wr(tadr[k], 32'hFFFFFFFF);
            chk("R9 timing no err", 32'(bus_err), 0);
        end
        chk("R9 width kept", 32'(width_px), 32'h154);
        chk("R9 depth kept", 32'(pix_depth), 8);
        chk("R9 no memory writes", 32'((pcnt - p0) + (lcnt - l0)), 0);
        // R11
        rd(32'h004, q, e);
        chk("R11 unmapped read data", q, 0);
        chk("R11 unmapped read err", 32'(e), 1);
        @(negedge clk);
        chk("R11 err one cycle", 32'(bus_err), 0);
        chk("R13 idle rdata", bus_rdata, 0);
        wr(32'h00C, 32'hFFFFFFFF);
        chk("R11 unmapped write err", 32'(bus_err), 1);
        chk("R11 unmapped write no effect", 32'(width_px), 32'h154);
        // R12
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        chk("R12 irq rises", 32'(irq_out), 1);
        @(negedge clk);
        chk("R12 irq holds", 32'(irq_out), 1);
        wr(32'h108, 32'h0);
        chk("R12 write lowers", 32'(irq_out), 0);
        frame_done = 1'b1; bus_addr = 21'h108; bus_wr = 1'b1;
        @(negedge clk);
        frame_done = 1'b0; bus_wr = 1'b0;
        chk("R12 write wins", 32'(irq_out), 0);
        // R10 soft reset
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
        p0 = pcnt; l0 = lcnt; pz0 = pnz; lz0 = lnz;
        wr(32'h100000, 32'h0);
        chk("R10 width cleared", 32'(width_px), 0);
        chk("R10 depth cleared", 32'(pix_depth), 1);
        chk("R10 start cleared", screen_start, 0);
        chk("R10 cursor cleared", 32'({cursor_x, cursor_y}), 0);
        chk("R10 irq cleared", 32'(irq_out), 0);
        @(negedge clk);
        wr(32'h1000 + 32'(500 * 8), 32'h1234);
        wr(32'h800 + 32'(200 * 8), 32'h123456);
        repeat (PAT_N + 20) @(negedge clk);
        check_cleared("R10 soft reset sweep", p0, l0, pz0, lz0);
        rd(32'h510, q, e);
        chk("R10 cursor colour cleared", q, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule